// File: doc/BRIEF.md
# Bit-Serial Recirculating Multiplier

This block multiplies two unsigned WIDTH-bit operands, read as positive binary fractions, with one single-bit full adder. The operands are loaded in parallel on a start pulse. After that the work advances only on cycles where the bit-time enable is high.

Each pass sends the multiplicand through the adder least significant bit first. The current multiplier bit gates it: when that bit is zero, zeros are added instead. The running partial sum circulates in a loop that is one bit-time shorter than a pass, so every pass shifts it right by one place without any shift network. The bit that leaves the adder first in each pass is final. It is retired into a separate low-half register.

After WIDTH passes of WIDTH+1 bit-times each, the circulating sum holds the high half of the product and the done flag rises. The caller pulses start, keeps supplying bit-time enables, and reads the full double-width product once done is high.

Top module: `srm_multiplier`

## Requirements
- R1: After reset, done is 0 and product is all zeros.
- R2: A start pulse while no multiply is in progress loads both operands. On the cycle after that edge, done is 0 and product is all zeros.
- R3: When done is high, product equals the exact 2*WIDTH-bit unsigned product of mcand_in and mplier_in as loaded. The low WIDTH bits are retired one per pass, lowest first, and the high WIDTH bits come from the final circulating sum.
- R4: With bit_en held high, done rises after exactly WIDTH*(WIDTH+1) enabled bit-times following the start edge. The start edge itself performs no bit-time. For WIDTH=8 this is 72; for WIDTH=3 it is 12.
- R5: A cycle with bit_en low makes no progress. Any pattern of stalls leaves both the number of enabled bit-times to completion and the product unchanged.
- R6: A start pulse while a multiply is in progress is ignored. The running multiply completes on schedule with its original operands.
- R7: Once done is high, done and product hold unchanged until the next start. A start after done begins a new multiply.
- R8: The adder carry is cleared at every pass boundary, so no carry leaks between passes. All-ones operands give the exact product (16'hFE01 for WIDTH=8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load operands and begin a multiply (ignored while busy) |
| bit_en | input | 1 | Bit-time enable; one serial step per high cycle |
| mcand_in | input | WIDTH | Multiplicand, parallel load |
| mplier_in | input | WIDTH | Multiplier, parallel load |
| done | output | 1 | High from completion until the next start |
| product | output | 2*WIDTH | Product; high half is the circulating sum, low half the retired bits |

## Verification
The bench builds two instances. The first uses the default WIDTH of 8 and walks a vector table of hand-worked products under several bit_en stall patterns. It then runs directed cases for restart-while-busy, hold-after-done and all-ones operands. The second instance uses WIDTH=3, where a whole multiply takes only 12 bit-times. That makes an exhaustive sweep of all 64 operand pairs cheap, so every carry and retire path of the serial loop is exercised against the bench's own arithmetic product.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } srm_state_e;

  // One-bit full addition: returns {carry_out, sum}
  function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic cin);
    logic s;
    logic co;
    s  = x ^ y ^ cin;
    co = (x & y) | (x & cin) | (y & cin);
    return {co, s};
  endfunction

  // Addend chosen by a multiplier bit: multiplicand bit or zero
  function automatic logic gated_addend(input logic mc_bit, input logic mp_bit);
    return mc_bit & mp_bit;
  endfunction

endpackage

// File: rtl/srm_serial_adder.sv
module srm_serial_adder (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr_carry,
  input  logic x,
  input  logic y,
  output logic sum,
  output logic carry_q
);
  import srm_pkg::*;

  logic [1:0] fa_res;

  always_comb begin
    fa_res = fa_bit(x, y, carry_q);
    sum    = fa_res[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
    end else if (clr_carry) begin
      carry_q <= 1'b0;
    end else if (step) begin
      carry_q <= fa_res[1];
    end
  end

endmodule

// File: rtl/srm_sequencer.sv
module srm_sequencer #(
  parameter int WIDTH = 8,
  localparam int BW = $clog2(WIDTH + 1),
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bit_en,
  output logic          load,
  output logic          step,
  output logic          first_bit,
  output logic          last_bit,
  output logic          pass_end,
  output logic          last_pass_end,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] bit_idx,
  output logic [PW-1:0] pass_idx
);
  import srm_pkg::*;

  srm_state_e state_q;
  logic [BW-1:0] bit_q;
  logic [PW-1:0] pass_q;
  logic last_pass;

  always_comb begin
    busy          = (state_q == ST_RUN);
    done          = (state_q == ST_DONE);
    load          = start && !busy;
    step          = busy && bit_en;
    first_bit     = (bit_q == '0);
    last_bit      = (bit_q == BW'(WIDTH));
    last_pass     = (pass_q == PW'(WIDTH - 1));
    pass_end      = step && last_bit;
    last_pass_end = pass_end && last_pass;
    bit_idx       = bit_q;
    pass_idx      = pass_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      pass_q  <= '0;
    end else if (load) begin
      state_q <= ST_RUN;
      bit_q   <= '0;
      pass_q  <= '0;
    end else if (step) begin
      if (last_bit) begin
        bit_q <= '0;
        if (last_pass) begin
          state_q <= ST_DONE;
          pass_q  <= '0;
        end else begin
          pass_q <= pass_q + PW'(1);
        end
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

endmodule

// File: rtl/srm_operand_loops.sv
module srm_operand_loops #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             first_bit,
  input  logic             last_bit,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             sum_bit,
  output logic             mcand_bit,
  output logic             psum_bit,
  output logic             mplier_bit,
  output logic [WIDTH-1:0] hi_half,
  output logic [WIDTH-1:0] lo_half
);

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplier_q;
  logic [WIDTH-1:0] psum_q;
  logic [WIDTH-1:0] lo_q;

  // The extra bit-time of each pass feeds zeros in place of the operands
  always_comb begin
    mcand_bit  = last_bit ? 1'b0 : mcand_q[0];
    psum_bit   = last_bit ? 1'b0 : psum_q[0];
    mplier_bit = mplier_q[0];
    hi_half    = psum_q;
    lo_half    = lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      psum_q   <= '0;
      lo_q     <= '0;
    end else if (load) begin
      mcand_q  <= a_in;
      mplier_q <= b_in;
      psum_q   <= '0;
      lo_q     <= '0;
    end else if (step) begin
      // Sum loop is WIDTH long but a pass lasts WIDTH+1 bit-times:
      // the extra step is the one-place right shift of the partial sum.
      psum_q <= {sum_bit, psum_q[WIDTH-1:1]};
      if (!last_bit) begin
        mcand_q <= {mcand_q[0], mcand_q[WIDTH-1:1]};
      end
      if (first_bit) begin
        lo_q <= {sum_bit, lo_q[WIDTH-1:1]};
      end
      if (last_bit) begin
        mplier_q <= {1'b0, mplier_q[WIDTH-1:1]};
      end
    end
  end

endmodule

// File: rtl/srm_multiplier.sv
module srm_multiplier #(
  parameter int WIDTH = 8,
  localparam int BW = $clog2(WIDTH + 1),
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               bit_en,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  import srm_pkg::*;

  logic          load;
  logic          step;
  logic          first_bit;
  logic          last_bit;
  logic          pass_end;
  logic          last_pass_end;
  logic          busy;
  logic [BW-1:0] bit_idx;
  logic [PW-1:0] pass_idx;
  logic          mcand_bit;
  logic          psum_bit;
  logic          mplier_bit;
  logic          addend_bit;
  logic          sum_bit;
  logic          carry_q;
  logic          carry_clr;
  logic [WIDTH-1:0] hi_half;
  logic [WIDTH-1:0] lo_half;

  srm_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .bit_en        (bit_en),
    .load          (load),
    .step          (step),
    .first_bit     (first_bit),
    .last_bit      (last_bit),
    .pass_end      (pass_end),
    .last_pass_end (last_pass_end),
    .busy          (busy),
    .done          (done),
    .bit_idx       (bit_idx),
    .pass_idx      (pass_idx)
  );

  srm_operand_loops #(.WIDTH(WIDTH)) u_loops (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .first_bit  (first_bit),
    .last_bit   (last_bit),
    .a_in       (mcand_in),
    .b_in       (mplier_in),
    .sum_bit    (sum_bit),
    .mcand_bit  (mcand_bit),
    .psum_bit   (psum_bit),
    .mplier_bit (mplier_bit),
    .hi_half    (hi_half),
    .lo_half    (lo_half)
  );

  always_comb begin
    addend_bit = gated_addend(mcand_bit, mplier_bit);
    carry_clr  = load | pass_end;
    product    = {hi_half, lo_half};
  end

  srm_serial_adder u_add (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .clr_carry (carry_clr),
    .x         (psum_bit),
    .y         (addend_bit),
    .sum       (sum_bit),
    .carry_q   (carry_q)
  );

endmodule

// File: rtl/srm_multiplier_chk.sv
module srm_multiplier_chk #(
  parameter int WIDTH = 8,
  localparam int BW = $clog2(WIDTH + 1),
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               bit_en,
  input logic               busy,
  input logic               done,
  input logic               first_bit,
  input logic               last_pass_end,
  input logic               carry_q,
  input logic [BW-1:0]      bit_idx,
  input logic [PW-1:0]      pass_idx,
  input logic [2*WIDTH-1:0] product
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!done && product == '0)); // R2

  AST_DONE_AFTER_LAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_pass_end)); // R4

  AST_STALL_NO_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> ($stable(bit_idx) && $stable(pass_idx))); // R5

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_pass_end) |=> (busy && !done)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(product))); // R7

  AST_CARRY_CLEAR_AT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && first_bit) |-> !carry_q); // R8

endmodule

bind srm_multiplier srm_multiplier_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .bit_en        (bit_en),
  .busy          (busy),
  .done          (done),
  .first_bit     (first_bit),
  .last_pass_end (last_pass_end),
  .carry_q       (carry_q),
  .bit_idx       (bit_idx),
  .pass_idx      (pass_idx),
  .product       (product)
);

// File: tb/srm_multiplier_tb.sv
`timescale 1ns/1ps
module srm_multiplier_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start8 = 1'b0;
  logic        en8 = 1'b0;
  logic [7:0]  a8 = '0;
  logic [7:0]  b8 = '0;
  logic        done8;
  logic [15:0] prod8;

  logic        start3 = 1'b0;
  logic        en3 = 1'b0;
  logic [2:0]  a3 = '0;
  logic [2:0]  b3 = '0;
  logic        done3;
  logic [5:0]  prod3;

  srm_multiplier #(.WIDTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start8), .bit_en(en8),
    .mcand_in(a8), .mplier_in(b8), .done(done8), .product(prod8)
  );

  srm_multiplier #(.WIDTH(3)) u_dut_w3 (
    .clk(clk), .rst_n(rst_n), .start(start3), .bit_en(en3),
    .mcand_in(a3), .mplier_in(b3), .done(done3), .product(prod3)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // {multiplicand, multiplier, product}
  localparam logic [31:0] VEC [8] = '{
    32'h0D0B_008F, 32'hFFFF_FE01, 32'h0000_0000, 32'h0101_0001,
    32'h8080_4000, 32'hAA55_3872, 32'h1234_03A8, 32'hFF01_00FF
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One WIDTH=8 multiply; gap selects bit_en high on every gap-th cycle
  task automatic mul8(input logic [7:0] a, input logic [7:0] b, input int gap,
                      output int cnt, output logic [15:0] p);
    @(negedge clk);
    a8 = a; b8 = b; start8 = 1'b1; en8 = 1'b0;
    @(negedge clk);
    start8 = 1'b0;
    chk(!done8 && prod8 == 16'h0, "R2 start clears", {47'h0, done8, prod8}, 64'h0);
    cnt = 0;
    for (int k = 0; k < 3000; k++) begin
      en8 = ((k % gap) == 0);
      @(negedge clk);
      if (en8) cnt++;
      if (done8) break;
    end
    en8 = 1'b0;
    p = prod8;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [15:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done8 == 1'b0, "R1 done after reset", 64'(done8), 64'h0);
    chk(prod8 == 16'h0, "R1 product after reset", 64'(prod8), 64'h0);
    chk(prod3 == 6'h0 && !done3, "R1 w3 after reset", 64'(prod3), 64'h0);

    // Table walk: product and bit-time count under varied stall patterns
    for (int i = 0; i < 8; i++) begin
      int gap;
      gap = 1 + (i % 3);
      mul8(VEC[i][31:24], VEC[i][23:16], gap, cnt, p);
      chk(p == VEC[i][15:0], "R3 table product", 64'(p), 64'(VEC[i][15:0]));
      if (gap == 1)
        chk(cnt == 72, "R4 bit-time count", 64'(cnt), 64'd72);
      else
        chk(cnt == 72, "R5 stalled bit-time count", 64'(cnt), 64'd72);
    end

    // R8: all ones stresses carries at every pass boundary
    mul8(8'hFF, 8'hFF, 1, cnt, p);
    chk(p == 16'hFE01, "R8 all-ones product", 64'(p), 64'hFE01);

    // R7: done and product hold while idle, bit_en toggling
    for (int k = 0; k < 12; k++) begin
      en8 = k[0];
      @(negedge clk);
      chk(done8 && prod8 == 16'hFE01, "R7 hold after done", {47'h0, done8, prod8}, 64'h1FE01);
    end
    en8 = 1'b0;

    // R6: start while busy is ignored
    @(negedge clk);
    a8 = 8'h0D; b8 = 8'h0B; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      en8 = 1'b1;
      @(negedge clk);
      cnt++;
    end
    a8 = 8'hFF; b8 = 8'hFF; start8 = 1'b1;
    @(negedge clk);
    cnt++;
    start8 = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (done8) break;
      @(negedge clk);
      cnt++;
    end
    en8 = 1'b0;
    chk(prod8 == 16'h008F, "R6 busy start ignored product", 64'(prod8), 64'h8F);
    chk(cnt == 72, "R6 busy start keeps schedule", 64'(cnt), 64'd72);

    // R7: a start after done begins a fresh multiply
    mul8(8'h03, 8'h05, 1, cnt, p);
    chk(p == 16'h000F, "R7 restart after done", 64'(p), 64'hF);

    // R3/R4: exhaustive on the 3-bit instance
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int n;
        @(negedge clk);
        a3 = 3'(a); b3 = 3'(b); start3 = 1'b1; en3 = 1'b0;
        @(negedge clk);
        start3 = 1'b0;
        n = 0;
        for (int k = 0; k < 100; k++) begin
          en3 = 1'b1;
          @(negedge clk);
          n++;
          if (done3) break;
        end
        en3 = 1'b0;
        chk(prod3 == 6'(a * b), "R3 w3 exhaustive product", 64'(prod3), 64'(a * b));
        chk(n == 12, "R4 w3 bit-time count", 64'(n), 64'd12);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule